// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block lets a clocked host read and write a 128K by 8 asynchronous static RAM. The host posts one access at a time: it raises a request together with a read/write flag, a 17-bit byte address and, for a write, a data byte. The controller then drives the memory pins for a fixed number of clock cycles and answers with a one-cycle ready pulse. On a read, the returned byte appears on the read-data output with that pulse.

All memory timing is converted into clock counts when the block is built. Each wait count is the smallest number of clock periods that covers the required nanoseconds, and never less than one. Writes are strobed by the write enable while both chip selects stay active. Output enable stays high for the whole write, so the memory never drives the pins while the controller does. After every read, the controller waits out the memory's output float time before it starts another access. The memory data pins come in as a separate input, and the controller drives an output byte plus an enable for the pad's tri-state driver.

Top module: `asram_ctl`

## Requirements
- R1: After reset and whenever no access is in progress, the memory is deselected: `mem_cs_n`=1, `mem_cs`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dout_en`=0. `ready` is 0 except for its pulse.
- R2: A write (`wr`=1) selects the memory for WC_N clock cycles, 14 at the default settings. Write enable is low for the first WP_N of those cycles (12 at default), with output enable high. The latched address and write data are driven, with the driver enabled, for every selected cycle.
- R3: A read (`wr`=0) selects the memory with output enable low and write enable high for RD_N cycles (14 at default). On the closing edge of the last cycle, `rdata` takes the value present on `mem_din`.
- R4: `ready` is high for exactly one cycle, in the cycle after the last selected cycle of an access. `rdata` keeps its value until the next read completes.
- R5: After a read, the memory stays deselected and the data driver stays off for TA_N cycles (6 at default). A pending request is only accepted in the cycle after that.
- R6: A request is accepted only while the controller is idle and `ready` is low. Address, data and flag are sampled at acceptance, and changes to them during the access have no effect on the memory pins.
- R7: Output enable and write enable are never low together, and the data driver is never enabled while output enable is low.
- R8: Each wait count is the ceiling of the required time divided by `CLK_NS`, with a minimum of one. The write strobe covers the pulse width, address-valid and data-setup minimums. The selected cycle covers the cycle minimum. The read covers the cycle, address-access and output-enable access times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host access request, held until ready |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Host byte address |
| wdata | input | 8 | Host write byte |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by the last read |
| mem_addr | output | 17 | Memory address pins |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dout | output | 8 | Byte driven toward the memory data pins |
| mem_dout_en | output | 1 | Enable of the data pad driver |
| mem_din | input | 8 | Byte sampled from the memory data pins |

## Verification
The hardest case to reach is a request that is already waiting when a read finishes. The controller must sit through the float window without touching the pins, and then start exactly one cycle after it. The bench arranges this by raising the next request in the same cycle it sees ready. It then counts idle cycles, expecting seven after a read and two after a write. A memory model in the bench returns unknown data until the address-access time has elapsed. It also times every write strobe and selected cycle, so a shortened wait count shows up as bad read data or as a timing violation.

// File: rtl/asram_ctl.sv
module asram_ctl #(
  parameter int AW     = 17,
  parameter int DW     = 8,
  parameter int CLK_NS = 5,
  parameter int T_RC   = 70,
  parameter int T_ACC  = 70,
  parameter int T_OE   = 40,
  parameter int T_WC   = 70,
  parameter int T_WP   = 55,
  parameter int T_AW   = 60,
  parameter int T_DW   = 30,
  parameter int T_FLT  = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_cs,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_en,
  input  logic [DW-1:0] mem_din
);

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RD_N = cdiv(mx(mx(T_RC, T_ACC), T_OE));
  localparam int WP_N = cdiv(mx(mx(T_WP, T_AW), T_DW));
  localparam int WC_N = mx(cdiv(T_WC), WP_N + 1);
  localparam int TA_N = cdiv(T_FLT);
  localparam int CW   = $clog2(mx(mx(RD_N, WC_N), TA_N) + 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_TA} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;

  wire sel = (st == S_RD) || (st == S_WR);

  assign mem_addr    = a_q;
  assign mem_dout    = d_q;
  assign mem_cs_n    = ~sel;
  assign mem_cs      = sel;
  assign mem_oe_n    = (st != S_RD);
  assign mem_we_n    = ~((st == S_WR) && (cnt < CW'(WP_N)));
  assign mem_dout_en = (st == S_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      a_q   <= '0;
      d_q   <= '0;
      rdata <= '0;
      ready <= 1'b0;
    end else begin
      ready <= 1'b0;
      case (st)
        S_IDLE: if (req && !ready) begin
          a_q <= addr;
          d_q <= wdata;
          cnt <= '0;
          st  <= wr ? S_WR : S_RD;
        end
        S_RD: if (cnt == CW'(RD_N - 1)) begin
          rdata <= mem_din;
          ready <= 1'b1;
          cnt   <= '0;
          st    <= S_TA;
        end else cnt <= cnt + 1'b1;
        S_WR: if (cnt == CW'(WC_N - 1)) begin
          ready <= 1'b1;
          cnt   <= '0;
          st    <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        S_TA: if (cnt == CW'(TA_N - 1)) begin
          cnt <= '0;
          st  <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_standby: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (!mem_cs && mem_oe_n && mem_we_n && !mem_dout_en));

  a_r2_we_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_cs && mem_dout_en));

  a_r6_pins_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

  a_r4_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  a_r5_no_drive_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |=> !mem_dout_en);

  a_r7_oe_we_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  a_r7_drive_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> mem_oe_n);

endmodule

// File: tb/asram_ctl_tb_top.sv
`timescale 1ns/1ps
module asram_ctl_tb_top;
  localparam int CLK_NS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0] wdata = '0;
  logic ready;
  logic [7:0] rdata;
  logic [16:0] mem_addr;
  logic mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dout_en;
  logic [7:0] mem_dout;
  logic [7:0] mem_din;

  always #2.5 clk = ~clk;

  asram_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", rq, $time, act, exp);
    end
  endtask

  // behavioural memory model with timing monitor
  logic [7:0] mem_arr [int];
  int sel_cyc = 0, we_cyc = 0, rd_cyc = 0;
  logic [16:0] w_a;
  logic [7:0] w_d;
  logic [7:0] din_q = 'x;
  assign mem_din = din_q;

  always @(posedge clk) begin
    automatic bit sel = !mem_cs_n && mem_cs;
    if (sel && !mem_oe_n) begin
      rd_cyc <= rd_cyc + 1;
      din_q  <= (rd_cyc >= 12) ? (mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)] : 8'h00) : 8'hxx;
    end else begin
      rd_cyc <= 0;
      din_q  <= 8'hxx;
    end
    if (sel && mem_dout_en && !mem_oe_n) check(0, "R7 contention", 1, 0);
    if (sel && !mem_we_n) begin
      we_cyc <= we_cyc + 1;
      w_a <= mem_addr;
      w_d <= mem_dout;
    end else if (we_cyc > 0) begin
      check(we_cyc * CLK_NS >= 55, "R8 write pulse width", we_cyc * CLK_NS, 55);
      check(we_cyc * CLK_NS >= 60, "R8 address valid to write end", we_cyc * CLK_NS, 60);
      mem_arr[int'(w_a)] = w_d;
      we_cyc <= 0;
    end
    if (sel) sel_cyc <= sel_cyc + 1;
    else if (sel_cyc > 0) begin
      check(sel_cyc * CLK_NS >= 70, "R8 cycle time", sel_cyc * CLK_NS, 70);
      sel_cyc <= 0;
    end
  end

  int gap_exp = 1;
  logic [7:0] last_rd = '0;

  task automatic access(input bit w, input logic [16:0] a, input logic [7:0] d, input logic [7:0] exp_rd);
    req = 1'b1; wr = w; addr = a; wdata = d;
    for (int g = 1; g < gap_exp; g++) begin
      @(negedge clk);
      check(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dout_en, "R5/R6 idle wait",
            {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dout_en}, 5'b10110);
    end
    @(negedge clk);
    addr = ~a; wdata = ~d; wr = ~w;   // R6: changes after acceptance must not matter
    for (int k = 0; k < 14; k++) begin
      if (k > 0) @(negedge clk);
      check(!mem_cs_n && mem_cs, w ? "R2 select" : "R3 select", {mem_cs_n, mem_cs}, 2'b01);
      check(mem_oe_n == w, w ? "R2 oe high" : "R3 oe low", mem_oe_n, w);
      check(mem_we_n == (w ? (k >= 12) : 1'b1), w ? "R2 we strobe" : "R3 we high", mem_we_n, w ? (k >= 12) : 1);
      check(mem_dout_en == w, "R7 driver", mem_dout_en, w);
      check(mem_addr == a, "R6 address held", mem_addr, a);
      if (w) check(mem_dout == d, "R2 data held", mem_dout, d);
      check(!ready, "R4 ready low during access", ready, 0);
    end
    @(negedge clk);
    check(ready, "R4 ready pulse", ready, 1);
    check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dout_en, "R1 deselect after access",
          {mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en}, 4'b1110);
    if (!w) begin
      check(rdata == exp_rd, "R3 read data", rdata, exp_rd);
      last_rd = exp_rd;
    end else begin
      check(rdata == last_rd, "R4 rdata kept over write", rdata, last_rd);
    end
    req = 1'b0;
    gap_exp = w ? 2 : 7;
  endtask

  logic [16:0] al [24];
  logic [7:0]  dl [24];

  initial begin
    repeat (3) @(negedge clk);
    check(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dout_en && !ready, "R1 reset state",
          {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dout_en, ready}, 6'b101100);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_cs_n && !ready, "R1 idle no request", {mem_cs_n, ready}, 2'b10);
    for (int i = 0; i < 24; i++) begin
      al[i] = (i == 0) ? 17'h00000 : (i == 23) ? 17'h1FFFF : 17'(i * 5000 + $urandom_range(0, 4000));
      dl[i] = 8'($urandom);
    end
    dl[0] = 8'hFF; dl[23] = 8'h00;
    for (int i = 0; i < 24; i++) access(1'b1, al[i], dl[i], 8'h00);
    for (int i = 23; i >= 0; i--) access(1'b0, al[i], 8'h5A, dl[i]);
    // write right after read, then read it back twice
    access(1'b1, al[5], 8'hC3, 8'h00);
    access(1'b0, al[5], 8'h00, 8'hC3);
    access(1'b0, al[5], 8'h00, 8'hC3);
    access(1'b0, al[23], 8'h00, 8'h00);
    repeat (10) @(negedge clk);
    check(mem_cs_n && !ready, "R1 idle at end", {mem_cs_n, ready}, 2'b10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule